// File: doc/BRIEF.md
# Dual Wiper Serial Control Register

This block is the digital control logic for a two-channel digital potentiometer. An external controller talks to it over three lines: an enable level, a serial clock and a serial data bit. All three lines are already synchronised to the system clock. While enable is high, each rising edge of the serial clock moves one data bit into a 17-bit frame register. That register holds a stack-select bit and two 8-bit wiper codes.

When enable drops, the whole frame is copied into holding registers. These drive the two committed wiper codes and the committed stack-select bit. A selected-wiper output models the stacked-output multiplexer.

The bit that is about to leave the frame register appears on a cascade output. Several blocks can therefore be chained on one bus. If the last cascade output is looped back to the data input, the controller can read the frame back without disturbing it.

Top module: `wiper_ctl`

## Requirements
- R1: After the active-low reset, the frame register and the holding registers are zero, so both codes, the select bit, the selected wiper and the cascade output read 0.
- R2: While the enable input is low, serial clock edges leave the frame register untouched. A following enable high-then-low with no clocks in between therefore commits the earlier contents again.
- R3: The frame layout is as follows. Bit 0 is the stack-select bit. Bits 1..8 are the channel-1 code with its MSB in bit 1. Bits 9..16 are the channel-0 code with its MSB in bit 9. On the wire the order is select, then channel 1 MSB to LSB, then channel 0 MSB to LSB.
- R4: The committed outputs change only on a high-to-low transition of enable. During a transfer they keep their previous values.
- R5: Each accepted bit enters at bit 16, and every other bit moves one place toward bit 0. The cascade output always shows bit 0, so the stack-select bit is the first bit to leave.
- R6: While enable is low, the cascade output equals the committed stack-select bit.
- R7: If the cascade output is fed back to the data input for exactly 17 serial clocks and then committed, all outputs are left unchanged.
- R8: The selected-wiper output equals the channel-0 code when the committed select bit is 0, and the channel-1 code when it is 1.
- R9: A transfer that is not a multiple of 17 bits is committed as the register stands. The result is the old bits moved down by the number of bits sent, with the new bits on top.
- R10: A serial clock that stays high for several system clocks causes exactly one shift.
- R11: After a transfer of 34 bits, the last 17 bits sent are the ones committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Serial port enable; a falling edge commits the frame |
| sclk_i | input | 1 | Serial clock; a rising edge shifts one bit in |
| sdat_i | input | 1 | Serial data |
| cas_o | output | 1 | Cascade output (frame bit 0) |
| code0_o | output | CODE_W | Committed channel-0 wiper code |
| code1_o | output | CODE_W | Committed channel-1 wiper code |
| stack_sel_o | output | 1 | Committed stack-select bit |
| wiper_sel_o | output | CODE_W | Wiper code picked by the stack-select bit |

## Verification
The bench builds the block with the default CODE_W of 8, which gives the full 17-bit frame. At that width, patterns with the MSB set only in one channel are possible, as are all-ones against all-zeros codes. This shows that bit ordering and channel placement are not mirrored. The same width lets the bench run full 17-bit loopback and 34-bit chained transfers within a short run, and also a 5-bit partial transfer whose misaligned commit can be predicted bit for bit.

// File: rtl/wctl_pkg.sv
package wctl_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic {
    PICK_CH0 = 1'b0,
    PICK_CH1 = 1'b1
  } stack_pick_e;

  function automatic int unsigned frame_w(input int unsigned code_w);
    return 1 + NCH * code_w;
  endfunction
endpackage

// File: rtl/wctl_edge.sv
module wctl_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic edge_o
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = d_i & ~lvl_q;
    end else begin : g_fall
      assign edge_o = ~d_i & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/wctl_shreg.sv
module wctl_shreg #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               step_i,
  input  logic               sdat_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] sh_d;
  logic               sh_en;

  always_comb begin
    sh_en = active_i & step_i;
    sh_d  = {sdat_i, sh_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign frame_o = sh_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(sh_q));

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && step_i) |=> (sh_q[FRAME_W-1] == $past(sdat_i)) &&
                             (sh_q[FRAME_W-2:0] == $past(sh_q[FRAME_W-1:1])));
endmodule

// File: rtl/wctl_hold.sv
module wctl_hold
  import wctl_pkg::*;
#(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned FRAME_W = 1 + NCH * CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CODE_W-1:0]  code0_o,
  output logic [CODE_W-1:0]  code1_o,
  output logic               sel_o,
  output logic [CODE_W-1:0]  wiper_o
);
  logic [FRAME_W-1:0]           hold_q;
  logic [FRAME_W-1:0]           hold_d;
  logic [NCH-1:0][CODE_W-1:0]   codes;
  stack_pick_e                  pick;

  always_comb begin
    hold_d = frame_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (commit_i) hold_q <= hold_d;
  end

  // Channel c occupies a CODE_W field, MSB at the lowest index; channel NCH-1 sits next to bit 0.
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      for (genvar j = 0; j < CODE_W; j++) begin : g_bit
        assign codes[c][CODE_W-1-j] = hold_q[1 + (NCH-1-c)*CODE_W + j];
      end
    end
  endgenerate

  assign pick    = stack_pick_e'(hold_q[0]);
  assign sel_o   = hold_q[0];
  assign code0_o = codes[0];
  assign code1_o = codes[1];
  assign wiper_o = (pick == PICK_CH1) ? codes[1] : codes[0];

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(hold_q));

  // R4
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (hold_q == $past(frame_i)));
endmodule

// File: rtl/wiper_ctl.sv
module wiper_ctl #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              cas_o,
  output logic [CODE_W-1:0] code0_o,
  output logic [CODE_W-1:0] code1_o,
  output logic              stack_sel_o,
  output logic [CODE_W-1:0] wiper_sel_o
);
  localparam int unsigned FRAME_W = wctl_pkg::frame_w(CODE_W);

  logic               sclk_rise;
  logic               en_fall;
  logic [FRAME_W-1:0] frame;

  wctl_edge #(.RISING(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .edge_o(sclk_rise)
  );

  wctl_edge #(.RISING(1'b0)) u_en_edge (
    .clk(clk), .rst_n(rst_n), .d_i(en_i), .edge_o(en_fall)
  );

  wctl_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .active_i(en_i), .step_i(sclk_rise),
    .sdat_i(sdat_i), .frame_o(frame)
  );

  wctl_hold #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .commit_i(en_fall), .frame_i(frame),
    .code0_o(code0_o), .code1_o(code1_o), .sel_o(stack_sel_o),
    .wiper_o(wiper_sel_o)
  );

  assign cas_o = frame[0];

  // R6
  cas_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !$past(en_i)) |-> (cas_o == stack_sel_o));
endmodule

// File: tb/wiper_ctl_test.sv
`timescale 1ns/1ps
module wiper_ctl_test;
  localparam int CW = 8;
  localparam int FW = 17;
  localparam int NV = 6;
  // {sel, code1, code0, expected selected wiper}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'hA5, 8'h3C, 8'h3C},
    {1'b1, 8'hA5, 8'h3C, 8'hA5},
    {1'b1, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'h80, 8'h01, 8'h01},
    {1'b1, 8'h7E, 8'h81, 8'h7E},
    {1'b0, 8'hFF, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic cas, ssel;
  logic [CW-1:0] c0, c1, wsel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [FW-1:0] model = '0;

  always #2 clk = ~clk;

  wiper_ctl #(.CODE_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .sclk_i(sclk), .sdat_i(sdat),
    .cas_o(cas), .code0_o(c0), .code1_o(c1), .stack_sel_o(ssel),
    .wiper_sel_o(wsel)
  );

  function automatic logic [FW-1:0] pack(input logic s, input logic [7:0] a1, input logic [7:0] a0);
    logic [FW-1:0] f;
    f[0] = s;
    for (int j = 0; j < 8; j++) begin
      f[1+j] = a1[7-j];
      f[9+j] = a0[7-j];
    end
    return f;
  endfunction

  function automatic logic [7:0] fld(input logic [FW-1:0] f, input int base);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[7-j] = f[base+j];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_commit(input string tag, input logic [FW-1:0] f);
    chk({tag, " code0"}, 32'(c0), 32'(fld(f, 9)));
    chk({tag, " code1"}, 32'(c1), 32'(fld(f, 1)));
    chk({tag, " sel"}, 32'(ssel), 32'(f[0]));
    chk({tag, " R8 wiper"}, 32'(wsel), 32'(f[0] ? fld(f, 1) : fld(f, 0 + 9)));
  endtask

  // Holds sclk high for three system clocks (R10: one shift per edge).
  task automatic send_bit(input logic b, input bit loop, input bit chk_cas);
    @(negedge clk);
    if (chk_cas) chk("R5 cascade", 32'(cas), 32'(model[0]));
    sdat = loop ? cas : b;
    model = {sdat, model[FW-1:1]};
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic begin_tx();
    @(negedge clk); en = 1'b1; @(negedge clk);
  endtask

  task automatic end_tx();
    @(negedge clk); en = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  task automatic send_frame(input logic [FW-1:0] f);
    for (int k = 0; k < FW; k++) send_bit(f[k], 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] committed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 code0", 32'(c0), 0);
    chk("R1 code1", 32'(c1), 0);
    chk("R1 sel", 32'(ssel), 0);
    chk("R1 wiper", 32'(wsel), 0);
    chk("R1 cascade", 32'(cas), 0);
    committed = '0;

    // R3, R4, R5, R6, R8 from the vector table
    for (int v = 0; v < NV; v++) begin
      logic [FW-1:0] f;
      f = pack(VEC[v][24], VEC[v][23:16], VEC[v][15:8]);
      begin_tx();
      send_frame(f);
      chk_commit("R4 before commit", committed);
      chk("R10 frame", 32'(model), 32'(f));
      end_tx();
      chk_commit("R3 commit", f);
      chk("R8 table wiper", 32'(wsel), 32'(VEC[v][7:0]));
      chk("R6 cascade idle", 32'(cas), 32'(ssel));
      committed = f;
    end

    // R2: clocks with enable low are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sdat = ~cas; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
      @(negedge clk);
      chk("R2 cascade", 32'(cas), 32'(committed[0]));
    end
    begin_tx();
    end_tx();
    chk_commit("R2 recommit", committed);

    // R7: loopback readback
    committed = pack(1'b1, 8'h96, 8'h4B);
    begin_tx(); send_frame(committed); end_tx();
    begin_tx();
    for (int k = 0; k < FW; k++) send_bit(1'b0, 1'b1, 1'b1);
    chk("R7 frame", 32'(model), 32'(committed));
    end_tx();
    chk_commit("R7 loopback", committed);

    // R9: partial 5-bit transfer
    begin_tx();
    for (int k = 0; k < 5; k++) send_bit(1'b1, 1'b0, 1'b1);
    end_tx();
    chk("R9 model", 32'(model), 32'({5'b11111, committed[FW-1:5]}));
    chk_commit("R9 partial", model);
    committed = model;

    // R11: 34-bit chained transfer
    begin_tx();
    send_frame(pack(1'b0, 8'h11, 8'h22));
    send_frame(pack(1'b1, 8'hC3, 8'h5A));
    end_tx();
    chk_commit("R11 chain", pack(1'b1, 8'hC3, 8'h5A));
    chk("R6 chain cascade", 32'(cas), 32'(1));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule